// File: doc/BRIEF.md
# Receive Pad-Insertion Stream Aligner

This block sits behind the receive side of a 64-bit 10G Ethernet MAC. It turns the MAC's word interface into a 64-bit AXI4-Stream. The MAC side gives one data word per cycle with start, end, error and valid qualifiers. A 3-bit occupancy code gives the number of valid bytes in the final word. The block puts six pad bytes in front of every frame, so that the IP header behind the 14-byte Ethernet header starts on an aligned boundary in downstream buffers. The first pad byte carries a fixed label that names the ingress port. The other five pad bytes are zero.

Inserting six bytes shifts every frame byte across a word boundary. Each output word is built from the low six bytes of the previous input word and the top two bytes of the current input word. When the last input word holds more than two valid bytes, the tail does not fit, and one extra output word is emitted. The occupancy of the final output word is recomputed. The output is a single registered stage under AXI4-Stream flow control. A synchronous clear drops any partly delivered frame.

Top module: `rx_pad_aligner`

## Requirements
- R1: After reset, outValid is 0 and inReady is 1.
- R2: The first output word of a frame is {label, five zero bytes, frame bytes 0 and 1}. The byte first on the wire sits in bits [63:56].
- R3: Each later output word is {the low six bytes of the previous input word, the top two bytes of the current input word}. The bytes keep their wire order.
- R4: tuser[2:0] of the final output word is (occ + 6) mod 8, where occ is the occupancy code of the final input word. tuser is 0 on every output word that is not the last.
- R5: When the final input word holds 3 to 8 valid bytes, one extra output word carries those bytes and has tlast set. When it holds 1 or 2 valid bytes, no extra word is emitted. A frame of L bytes therefore gives ceil((L+6)/8) output words.
- R6: tuser[3] of the final output word equals the error qualifier of the end-of-frame input word. Error qualifiers on earlier words are not used.
- R7: While outValid is 1 and outReady is 0, the output word, tuser and tlast hold stable and inReady is 0.
- R8: A clear pulse drops the held output word, any pending extra word and the open-frame state. Non-start words that arrive after the clear are ignored until the next start.
- R9: An input word that arrives outside a frame without the start qualifier is consumed and produces no output.
- R10: Occupancy code 0 means all eight bytes are valid, in both input and output codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | MAC-domain clock |
| rst | input | 1 | Synchronous reset, active high |
| clear | input | 1 | Synchronous clear, drops partial frame state |
| inData | input | 64 | Received word from the MAC, first byte in [63:56] |
| inOcc | input | 3 | Valid bytes in the end-of-frame word, 0 = eight |
| inSof | input | 1 | Word is the first of a frame |
| inEof | input | 1 | Word is the last of a frame |
| inErr | input | 1 | Frame error qualifier, used on the end-of-frame word |
| inValid | input | 1 | Input word is present |
| inReady | output | 1 | Block takes the input word this cycle |
| outData | output | 64 | Aligned stream data (tdata) |
| outUser | output | 4 | {error, final-word occupancy} on the last word, otherwise 0 |
| outLast | output | 1 | Last word of a frame (tlast) |
| outValid | output | 1 | Stream word valid (tvalid) |
| outReady | input | 1 | Downstream accepts the word (tready) |

## Verification
An input word taken at a rising edge shows up on the output port one cycle later. The extra tail word follows one cycle after the final body word is taken downstream, or later if the output is stalled. A clear removes outValid at the next edge. The bench drives inputs and samples every output at the falling edge. It treats a word as transferred only when it sees outValid and outReady together before the next rising edge. It compares that word against a byte stream computed arithmetically from the frame length, the label and the byte pattern. Stall windows are checked for stability at each falling edge while outReady stays low.

// File: rtl/rx_pad_pkg.sv
package rx_pad_pkg;
  // Strobes from control to datapath, valid for one cycle.
  typedef struct packed {
    logic capHead;   // load first output word of a frame
    logic capBody;   // load a shifted continuation word
    logic finalNow;  // loaded word closes the frame
    logic emitSpill; // load the extra tail word
  } padCtl_t;
endpackage

// File: rtl/rx_pad_ctrl.sv
module rx_pad_ctrl
  import rx_pad_pkg::*;
#(
  parameter int LANES = 8,
  parameter int PAD   = 6,
  parameter int OCC_W = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             inValid,
  input  logic             inSof,
  input  logic             inEof,
  input  logic [OCC_W-1:0] inOcc,
  input  logic             outReady,
  output logic             inReady,
  output logic             outValid,
  output logic             spillPending,
  output padCtl_t          ctl
);
  localparam int HEAD = LANES - PAD;  // frame bytes that fit in the head word

  logic outValidQ, inFrameQ, spillQ;
  logic advance, take, shortTail;
  logic [OCC_W:0] tailCount;

  assign advance   = !outValidQ || outReady;
  assign inReady   = advance && !spillQ;
  assign take      = inValid && inReady && (inSof || inFrameQ) && !clear;
  assign tailCount = (inOcc == '0) ? (OCC_W+1)'(LANES) : {1'b0, inOcc};
  assign shortTail = tailCount <= (OCC_W+1)'(HEAD);

  always_comb begin
    ctl.capHead   = take && inSof;
    ctl.capBody   = take && !inSof;
    ctl.finalNow  = take && inEof && shortTail;
    ctl.emitSpill = spillQ && advance && !clear;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      outValidQ <= 1'b0;
      inFrameQ  <= 1'b0;
      spillQ    <= 1'b0;
    end else begin
      if (take) inFrameQ <= !inEof;
      if (ctl.emitSpill) spillQ <= 1'b0;
      else if (take && inEof && !shortTail) spillQ <= 1'b1;
      if (take || ctl.emitSpill) outValidQ <= 1'b1;
      else if (outReady) outValidQ <= 1'b0;
    end
  end

  assign outValid     = outValidQ;
  assign spillPending = spillQ;

  // R8: clear empties the output stage and the pending tail
  assert_clear_drops_R8: assert property (@(posedge clk) disable iff (rst)
    clear |=> !outValidQ && !spillQ);

  // R5: a pending tail word always turns into a valid output word
  assert_spill_emits_R5: assert property (@(posedge clk) disable iff (rst)
    spillQ && advance && !clear |=> outValidQ && !spillQ);

  // R9: a word without start outside a frame never makes output
  assert_orphan_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    !inFrameQ && !spillQ && inValid && inReady && !inSof && !clear && !outValidQ |=> !outValidQ);
endmodule

// File: rtl/rx_pad_dpath.sv
module rx_pad_dpath
  import rx_pad_pkg::*;
#(
  parameter int           LANES      = 8,
  parameter int           PAD        = 6,
  parameter int           OCC_W      = $clog2(LANES),
  parameter logic [7:0]   PORT_LABEL = 8'hA5
) (
  input  logic               clk,
  input  logic               rst,
  input  padCtl_t            ctl,
  input  logic [LANES*8-1:0] inData,
  input  logic [OCC_W-1:0]   inOcc,
  input  logic               inErr,
  output logic [LANES*8-1:0] outData,
  output logic [OCC_W:0]     outUser,
  output logic               outLast
);
  localparam int W      = LANES * 8;
  localparam int HEAD_W = (LANES - PAD) * 8;
  localparam int CARRY_W = PAD * 8;

  logic [W-1:0]       dataQ;
  logic [OCC_W:0]     userQ, tailUserQ, tailUser;
  logic               lastQ;
  logic [CARRY_W-1:0] carryQ;

  // occupancy wraps naturally because LANES is a power of two
  assign tailUser = {inErr, inOcc + OCC_W'(PAD)};

  always_ff @(posedge clk) begin
    if (rst) begin
      dataQ     <= '0;
      userQ     <= '0;
      lastQ     <= 1'b0;
      carryQ    <= '0;
      tailUserQ <= '0;
    end else if (ctl.capHead || ctl.capBody) begin
      if (ctl.capHead)
        dataQ <= {PORT_LABEL, {(PAD-1)*8{1'b0}}, inData[W-1 -: HEAD_W]};
      else
        dataQ <= {carryQ, inData[W-1 -: HEAD_W]};
      carryQ    <= inData[CARRY_W-1:0];
      lastQ     <= ctl.finalNow;
      userQ     <= ctl.finalNow ? tailUser : '0;
      tailUserQ <= tailUser;
    end else if (ctl.emitSpill) begin
      dataQ <= {carryQ, {HEAD_W{1'b0}}};
      lastQ <= 1'b1;
      userQ <= tailUserQ;
    end
  end

  assign outData = dataQ;
  assign outUser = userQ;
  assign outLast = lastQ;

  // R2: a head load places the label and the zero pad at the top of the word
  assert_head_label_R2: assert property (@(posedge clk) disable iff (rst)
    ctl.capHead |=> outData[W-1 -: 8] == PORT_LABEL && outData[W-9 -: (PAD-1)*8] == '0);

  // R5: the extra tail word always closes the frame with empty low lanes
  assert_spill_last_R5: assert property (@(posedge clk) disable iff (rst)
    ctl.emitSpill |=> outLast && outData[HEAD_W-1:0] == '0);
endmodule

// File: rtl/rx_pad_aligner.sv
module rx_pad_aligner
  import rx_pad_pkg::*;
#(
  parameter int         LANES      = 8,  // power of two
  parameter int         PAD        = 6,  // 1 .. LANES-1
  parameter logic [7:0] PORT_LABEL = 8'hA5,
  localparam int        W          = LANES * 8,
  localparam int        OCC_W      = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic [W-1:0]     inData,
  input  logic [OCC_W-1:0] inOcc,
  input  logic             inSof,
  input  logic             inEof,
  input  logic             inErr,
  input  logic             inValid,
  output logic             inReady,
  output logic [W-1:0]     outData,
  output logic [OCC_W:0]   outUser,
  output logic             outLast,
  output logic             outValid,
  input  logic             outReady
);
  padCtl_t ctl;
  logic    spillPending;

  rx_pad_ctrl #(.LANES(LANES), .PAD(PAD), .OCC_W(OCC_W)) u_ctrl (
    .clk(clk), .rst(rst), .clear(clear),
    .inValid(inValid), .inSof(inSof), .inEof(inEof), .inOcc(inOcc),
    .outReady(outReady), .inReady(inReady), .outValid(outValid),
    .spillPending(spillPending), .ctl(ctl)
  );

  rx_pad_dpath #(.LANES(LANES), .PAD(PAD), .OCC_W(OCC_W), .PORT_LABEL(PORT_LABEL)) u_dpath (
    .clk(clk), .rst(rst), .ctl(ctl),
    .inData(inData), .inOcc(inOcc), .inErr(inErr),
    .outData(outData), .outUser(outUser), .outLast(outLast)
  );

  // R7: a stalled word holds and no input is taken
  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady && !clear |=> outValid && $stable(outData) && $stable(outUser) && $stable(outLast));

  assert_stall_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |-> !inReady);

  // R4: sideband is empty on words that do not close a frame
  assert_user_zero_R4: assert property (@(posedge clk) disable iff (rst)
    outValid && !outLast |-> outUser == '0);

  // R5: while a tail word is pending the visible word is not the last
  assert_spill_notlast_R5: assert property (@(posedge clk) disable iff (rst)
    spillPending |-> outValid && !outLast);
endmodule

// File: tb/rx_pad_aligner_bench.sv
`timescale 1ns/1ps
module rx_pad_aligner_bench;
  localparam logic [7:0] LABEL = 8'h5C;

  logic clk = 0, rst = 1, clear = 0;
  logic [63:0] inData = '0;
  logic [2:0]  inOcc = '0;
  logic inSof = 0, inEof = 0, inErr = 0, inValid = 0, outReady = 0;
  logic inReady, outLast, outValid;
  logic [63:0] outData;
  logic [3:0]  outUser;

  always #2 clk = ~clk;

  rx_pad_aligner #(.PORT_LABEL(LABEL)) u_rx_pad_aligner (
    .clk(clk), .rst(rst), .clear(clear), .inData(inData), .inOcc(inOcc),
    .inSof(inSof), .inEof(inEof), .inErr(inErr), .inValid(inValid), .inReady(inReady),
    .outData(outData), .outUser(outUser), .outLast(outLast), .outValid(outValid),
    .outReady(outReady)
  );

  int checks = 0, failures = 0, cyc = 0, readyMode = 0, posInFrame = 0;
  logic [63:0] inDq[$];
  logic [5:0]  inCq[$];   // {sof, eof, err, occ}
  logic [63:0] expD[$];
  logic [4:0]  expU[$];   // {last, user}
  string       expTag[$];
  int          expLen[$];
  logic        heldValid = 0;
  logic [63:0] heldData;
  logic [4:0]  heldUL;

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] fb(int f, int i);
    return 8'(f * 37 + i * 11 + 1);
  endfunction

  task automatic pushFrame(int f, int len, bit err);
    logic [7:0] s[$];
    int nOut, nIn;
    s.push_back(LABEL);
    for (int i = 0; i < 5; i++) s.push_back(8'h00);
    for (int i = 0; i < len; i++) s.push_back(fb(f, i));
    nOut = (len + 13) / 8;
    nIn  = (len + 7) / 8;
    for (int w = 0; w < nOut; w++) begin
      logic [63:0] d = '0;
      bit last = (w == nOut - 1);
      for (int k = 0; k < 8; k++)
        if (8 * w + k < len + 6) d[63 - 8 * k -: 8] = s[8 * w + k];
      expD.push_back(d);
      expU.push_back({last, last ? {err, 3'((len + 6) % 8)} : 4'h0});
      expTag.push_back(w == 0 ? "R2" : (last ? "R4" : "R3"));
    end
    expLen.push_back(nOut);
    for (int w = 0; w < nIn; w++) begin
      logic [63:0] d = '0;
      bit eof = (w == nIn - 1);
      for (int k = 0; k < 8; k++)
        if (8 * w + k < len) d[63 - 8 * k -: 8] = fb(f, 8 * w + k);
      inDq.push_back(d);
      // err on non-final words is the inverse, so only the final one may matter (R6)
      inCq.push_back({w == 0, eof, eof ? err : !err, 3'(len % 8)});
    end
  endtask

  task automatic observe();
    logic [63:0] d;
    logic [4:0] ul;
    string tag;
    if (expD.size() == 0) begin
      chk(0, "R9 unexpected word", outData, 64'h0);
      return;
    end
    d = expD.pop_front(); ul = expU.pop_front(); tag = expTag.pop_front();
    chk(outData == d, tag, outData, d);
    chk({outLast, outUser} == ul, "R4 user/last", {59'h0, outLast, outUser}, {59'h0, ul});
    if (ul[4]) begin
      int n = expLen.pop_front();
      chk(outUser[3] == ul[3], "R6 error flag", {63'h0, outUser[3]}, {63'h0, ul[3]});
      chk(posInFrame + 1 == n, "R5 word count", 64'(posInFrame + 1), 64'(n));
      if (ul[2:0] == 3'd0) chk(outUser[2:0] == 3'd0, "R10 full word", {61'h0, outUser[2:0]}, 64'h0);
      posInFrame = 0;
    end else posInFrame++;
  endtask

  task automatic step();
    bit acc;
    @(negedge clk);
    cyc++;
    case (readyMode)
      0: outReady = 1;
      1: outReady = (cyc % 3 != 1);
      default: outReady = 0;
    endcase
    if (inDq.size() > 0) begin
      inValid = 1;
      {inSof, inEof, inErr, inOcc} = inCq[0];
      inData = inDq[0];
    end else begin
      inValid = 0; inSof = 0; inEof = 0; inErr = 0; inOcc = '0; inData = '0;
    end
    #1;
    if (heldValid)
      chk(outValid && outData == heldData && {outLast, outUser} == heldUL,
          "R7 hold", outData, heldData);
    if (outValid && !outReady) begin
      chk(!inReady, "R7 input blocked", {63'h0, inReady}, 64'h0);
      heldValid = 1; heldData = outData; heldUL = {outLast, outUser};
    end else heldValid = 0;
    if (outValid && outReady) observe();
    acc = inValid && inReady;
    @(posedge clk);
    if (acc) begin
      void'(inDq.pop_front());
      void'(inCq.pop_front());
    end
  endtask

  task automatic runUntilIdle();
    int guard = 0;
    while ((inDq.size() > 0 || expD.size() > 0) && guard < 5000) begin
      step();
      guard++;
    end
    if (guard >= 5000) chk(0, "R3 stream stalled", 64'(expD.size()), 64'h0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    chk(!outValid, "R1 reset valid", {63'h0, outValid}, 64'h0);
    chk(inReady, "R1 reset ready", {63'h0, inReady}, 64'h1);

    // length sweep, back to back, with orphan words between frames (R9)
    for (int mode = 0; mode < 2; mode++) begin
      readyMode = mode;
      for (int len = 1; len <= 24; len++) begin
        if (len % 5 == 0) begin
          inDq.push_back(64'hDEAD_BEEF_0BAD_F00D);
          inCq.push_back({1'b0, 1'b1, 1'b0, 3'd3});
        end
        pushFrame(mode * 100 + len, len, (len + mode) % 2 == 1);
      end
      runUntilIdle();
    end

    // lone orphan word on an idle block
    readyMode = 0;
    inDq.push_back(64'h1122_3344_5566_7788);
    inCq.push_back({1'b0, 1'b0, 1'b0, 3'd0});
    runUntilIdle();
    repeat (3) step();
    chk(!outValid, "R9 orphan no output", {63'h0, outValid}, 64'h0);

    // clear in the middle of a stalled frame
    readyMode = 2;
    inDq.push_back(64'hA1A2_A3A4_A5A6_A7A8);
    inCq.push_back({1'b1, 1'b0, 1'b0, 3'd0});
    while (inDq.size() > 0) step();
    repeat (2) step();
    chk(outValid, "R8 word held before clear", {63'h0, outValid}, 64'h1);
    @(negedge clk);
    clear = 1; inValid = 0;
    @(posedge clk);
    @(negedge clk);
    clear = 0; heldValid = 0;
    #1;
    chk(!outValid, "R8 clear drops word", {63'h0, outValid}, 64'h0);
    readyMode = 0;
    // continuation of the dropped frame must be ignored
    inDq.push_back(64'hB1B2_B3B4_B5B6_B7B8);
    inCq.push_back({1'b0, 1'b1, 1'b0, 3'd5});
    pushFrame(7, 13, 1'b0);
    runUntilIdle();
    repeat (3) step();
    chk(!outValid, "R8 idle after clear", {63'h0, outValid}, 64'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule